// File: doc/BRIEF.md
# Self-Programming Flash Command Controller

This block sits between a CPU core and the program flash array and turns self-programming commands into buffer updates and flash requests. Software first writes a 4-bit control value. Bit 0 is the enable bit and bits 3:1 select the operation. That write arms a short execution window. An execute strobe that arrives inside the window runs the selected operation against the 16-bit pointer and the 16-bit data word that the core presents with the strobe. If the strobe comes late, or never comes, the window lapses and nothing happens.

Three operations exist. A fill stores one 16-bit word into a one-page temporary buffer of 64 words. A page erase issues a single request pulse to the flash array. A page write issues a single request pulse and, when the array signals done, empties the buffer and hands back a pointer aimed at the first word of the following page. The pointer is split into a page field in bits 13:7, a word field in bits 6:1 and a byte bit in bit 0. Bits 15:14 are never used. A combined busy flag lets software poll until the block can take the next command. The flash array reads buffer words through a registered read port.

Top module: `spm_cmd_ctrl`

## Requirements
- R1: An execute strobe runs an operation only if it arrives 1 to 4 cycles after the arming control write, counting the edge of the write as cycle 0. A strobe in cycle 5 or later does nothing. The first accepted strobe closes the window.
- R2: Control value 4'b0001 is a fill. The data word is stored at buffer word ptr[6:1]. It appears on rd_data_o one cycle after rd_idx_i selects that word.
- R3: Control value 4'b0011 is a page erase. It gives a one-cycle erase_req_o pulse in the cycle after the strobe, with page_o = ptr[13:7]. Pointer bits 15:14 have no effect.
- R4: Control value 4'b0101 is a page write. It gives a one-cycle write_req_o pulse with page_o = ptr[13:7]. The data word is ignored.
- R5: A command whose ptr[0] is 1 is rejected, and so is a page write whose ptr[6:0] is nonzero. A rejected command raises err_o and issues no request and no buffer store. The next command that is executed and accepted clears err_o.
- R6: In the cycle after flash_done_i ends a page write, ptr_load_o pulses for one cycle. At the same time ptr_o = {2'b00, page+1 modulo 128, 7'b0000000}.
- R7: busy_o is high from an enabling control write until its window closes. For an erase or a write, it stays high until the cycle after flash_done_i.
- R8: Control writes are ignored while an erase or write waits for flash_done_i, and no execute strobe is accepted during that time.
- R9: A control value with bit 0 set and any other code is a no-op. Its strobe still closes the window. A control value with bit 0 clear arms nothing and closes any open window.
- R10: A completed page write clears every buffer word to zero. A completed erase leaves the buffer unchanged.
- R11: If a control write and an accepted strobe fall in the same cycle, the strobe runs the previously written code and the write opens a fresh window.
- R12: If rd_idx_i selects a word in the same cycle that a fill stores to it, rd_data_o shows the old value first and the new value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Control value: bit 0 enable, bits 3:1 operation code |
| exec_i | input | 1 | Execute strobe from the core |
| ptr_i | input | 16 | Address pointer |
| data_i | input | 16 | Data word for buffer fill |
| busy_o | output | 1 | Window open or flash operation in progress |
| err_o | output | 1 | Last executed command was rejected |
| erase_req_o | output | 1 | One-cycle page erase request |
| write_req_o | output | 1 | One-cycle page write request |
| page_o | output | 7 | Page number for the request |
| flash_done_i | input | 1 | Flash array finished the request |
| ptr_load_o | output | 1 | One-cycle pulse: load ptr_o into the pointer |
| ptr_o | output | 16 | Pointer to the first word of the next page |
| rd_idx_i | input | 6 | Buffer word index for reading |
| rd_data_o | output | 16 | Registered buffer read data |

## Verification
Two pairs of functions can land on the same clock edge. In the first pair, the execute strobe consumes an open window while a new control write re-arms it. The bench provokes this by asserting both strobes on one edge, after an erase arming. It judges the result by an erase request on that edge and by a write request from a strobe that follows the erase completion without a second control write. In the second pair, a buffer fill stores to the word that the read port is sampling. The bench expects the previous content first and the new word on the next cycle. Randomized fills against a bench-side buffer model and randomized window delays cover the rest.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int PTR_W  = 16;
  localparam int DATA_W = 16;
  localparam int WORD_BITS = 6;
  localparam int PAGE_BITS = 7;
  localparam int WIN_CYC   = 4;
  localparam int BUF_DEPTH = 1 << WORD_BITS;
  localparam int PAGE_LSB  = WORD_BITS + 1;
  localparam int PAGE_MSB  = PAGE_LSB + PAGE_BITS - 1;

  typedef logic [2:0] op_code_t;
  localparam op_code_t OPC_FILL  = 3'b000;
  localparam op_code_t OPC_ERASE = 3'b001;
  localparam op_code_t OPC_WRITE = 3'b010;
endpackage

// File: rtl/spm_window.sv
module spm_window #(
  parameter int WIN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [3:0] ctl_wdata,
  input  logic       exec,
  input  logic       op_busy,
  output logic       fire,
  output logic [2:0] code,
  output logic       open
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] cnt_q;
  logic [2:0]    code_q;

  assign open = (cnt_q != '0);
  assign fire = exec && open && !op_busy;
  assign code = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (ctl_we && !op_busy) begin
      code_q <= ctl_wdata[3:1];
      cnt_q  <= ctl_wdata[0] ? CW'(WIN) : '0;
    end else if (fire) begin
      cnt_q <= '0;
    end else if (open) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_win_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(WIN));
  assert_win_close_R1: assert property (@(posedge clk) disable iff (rst)
    (fire && !ctl_we) |=> !open);
endmodule

// File: rtl/spm_buffer.sv
module spm_buffer #(
  parameter int DEPTH = 64,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [DW-1:0]            wdata,
  input  logic                     clr,
  input  logic [$clog2(DEPTH)-1:0] ridx,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DW-1:0]    mem_rd_q;
  logic             vld_rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    mem_rd_q <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) valid_q <= '0;
    else if (we)    valid_q[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_rd_q <= 1'b0;
    else     vld_rd_q <= valid_q[ridx];
  end

  assign rdata = vld_rd_q ? mem_rd_q : '0;

  assert_no_fill_on_clear_R10: assert property (@(posedge clk) disable iff (rst)
    !(we && clr));
  assert_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (valid_q == '0));
endmodule

// File: rtl/spm_seq.sv
module spm_seq
  import spm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fire,
  input  op_code_t              code,
  input  logic [PTR_W-1:0]      ptr,
  input  logic                  flash_done,
  output logic                  op_busy,
  output logic                  buf_we,
  output logic [WORD_BITS-1:0]  buf_widx,
  output logic                  buf_clr,
  output logic                  err,
  output logic                  erase_req,
  output logic                  write_req,
  output logic [PAGE_BITS-1:0]  page,
  output logic                  ptr_load,
  output logic [PTR_W-1:0]      ptr_out
);
  logic busy_q, is_write_q, err_q, ereq_q, wreq_q, load_q;
  logic [PAGE_BITS-1:0] page_q;
  logic [PTR_W-1:0]     nptr_q;
  logic bad_byte, bad_wr_align, do_fill, do_erase, do_write, reject, finish;

  assign bad_byte     = ptr[0];
  assign bad_wr_align = (ptr[WORD_BITS:0] != '0);
  assign do_fill  = fire && (code == OPC_FILL)  && !bad_byte;
  assign do_erase = fire && (code == OPC_ERASE) && !bad_byte;
  assign do_write = fire && (code == OPC_WRITE) && !bad_wr_align;
  assign reject   = fire && (((code == OPC_FILL || code == OPC_ERASE) && bad_byte) ||
                             ((code == OPC_WRITE) && bad_wr_align));
  assign finish   = busy_q && flash_done;

  assign buf_we   = do_fill;
  assign buf_widx = ptr[WORD_BITS:1];
  assign buf_clr  = finish && is_write_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; is_write_q <= 1'b0; err_q <= 1'b0;
      ereq_q <= 1'b0; wreq_q <= 1'b0; load_q <= 1'b0;
      page_q <= '0;   nptr_q <= '0;
    end else begin
      ereq_q <= do_erase;
      wreq_q <= do_write;
      load_q <= buf_clr;
      if (fire) err_q <= reject;
      if (do_erase || do_write) begin
        busy_q     <= 1'b1;
        is_write_q <= do_write;
        page_q     <= ptr[PAGE_MSB:PAGE_LSB];
      end else if (finish) begin
        busy_q <= 1'b0;
      end
      if (buf_clr)
        nptr_q <= {{(PTR_W-PAGE_MSB-1){1'b0}}, page_q + 1'b1, {PAGE_LSB{1'b0}}};
    end
  end

  assign op_busy   = busy_q;
  assign err       = err_q;
  assign erase_req = ereq_q;
  assign write_req = wreq_q;
  assign page      = page_q;
  assign ptr_load  = load_q;
  assign ptr_out   = nptr_q;

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> !erase_req);
  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    write_req |=> !write_req);
  assert_one_req_R4: assert property (@(posedge clk) disable iff (rst)
    !(erase_req && write_req));
  assert_req_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (erase_req || write_req) |-> op_busy);
  assert_no_fire_busy_R8: assert property (@(posedge clk) disable iff (rst)
    op_busy |-> !fire);
  assert_ptr_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    ptr_load |-> (ptr_out[PAGE_LSB-1:0] == '0));
  assert_req_no_err_R5: assert property (@(posedge clk) disable iff (rst)
    (erase_req || write_req) |-> !err);
endmodule

// File: rtl/spm_cmd_ctrl.sv
module spm_cmd_ctrl
  import spm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we_i,
  input  logic [3:0]           ctl_wdata_i,
  input  logic                 exec_i,
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic                 busy_o,
  output logic                 err_o,
  output logic                 erase_req_o,
  output logic                 write_req_o,
  output logic [PAGE_BITS-1:0] page_o,
  input  logic                 flash_done_i,
  output logic                 ptr_load_o,
  output logic [PTR_W-1:0]     ptr_o,
  input  logic [WORD_BITS-1:0] rd_idx_i,
  output logic [DATA_W-1:0]    rd_data_o
);
  logic                 fire, win_open, op_busy, buf_we, buf_clr;
  op_code_t             code;
  logic [WORD_BITS-1:0] buf_widx;

  spm_window #(.WIN(WIN_CYC)) u_win (
    .clk(clk), .rst(rst), .ctl_we(ctl_we_i), .ctl_wdata(ctl_wdata_i),
    .exec(exec_i), .op_busy(op_busy), .fire(fire), .code(code), .open(win_open)
  );

  spm_seq u_seq (
    .clk(clk), .rst(rst), .fire(fire), .code(code), .ptr(ptr_i),
    .flash_done(flash_done_i), .op_busy(op_busy), .buf_we(buf_we),
    .buf_widx(buf_widx), .buf_clr(buf_clr), .err(err_o),
    .erase_req(erase_req_o), .write_req(write_req_o), .page(page_o),
    .ptr_load(ptr_load_o), .ptr_out(ptr_o)
  );

  spm_buffer #(.DEPTH(BUF_DEPTH), .DW(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .widx(buf_widx), .wdata(data_i),
    .clr(buf_clr), .ridx(rd_idx_i), .rdata(rd_data_o)
  );

  assign busy_o = win_open || op_busy;

  assert_busy_cover_R7: assert property (@(posedge clk) disable iff (rst)
    (erase_req_o || write_req_o) |-> busy_o);
  assert_busy_arm_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl_we_i && ctl_wdata_i[0] && !busy_o) |=> busy_o);
endmodule

// File: tb/sim_spm_cmd_ctrl.sv
module sim_spm_cmd_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 0, exec = 0, done = 0;
  logic [3:0]  wdata = 0;
  logic [15:0] ptr = 0, data = 0, ptr_o, rd_data;
  logic [5:0]  rd_idx = 0;
  logic [6:0]  page;
  logic busy, err, ereq, wreq, pload;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] model [64];

  always #2 clk = ~clk;

  spm_cmd_ctrl u0 (
    .clk(clk), .rst(rst), .ctl_we_i(ctl_we), .ctl_wdata_i(wdata), .exec_i(exec),
    .ptr_i(ptr), .data_i(data), .busy_o(busy), .err_o(err), .erase_req_o(ereq),
    .write_req_o(wreq), .page_o(page), .flash_done_i(done), .ptr_load_o(pload),
    .ptr_o(ptr_o), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  function automatic logic [15:0] mk_ptr(logic [1:0] hi, logic [6:0] pg, logic [5:0] w, logic b);
    return {hi, pg, w, b};
  endfunction
  function automatic logic [15:0] next_ptr(logic [6:0] pg);
    return {2'b00, pg + 7'd1, 7'd0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic ctl(logic [3:0] v);
    ctl_we = 1; wdata = v; tick(); ctl_we = 0;
  endtask
  task automatic ex(logic [15:0] p, logic [15:0] d);
    exec = 1; ptr = p; data = d; tick(); exec = 0;
  endtask
  task automatic finish_op();
    done = 1; tick(); done = 0;
  endtask
  task automatic rd(logic [5:0] i, string req, logic [15:0] exp);
    rd_idx = i; tick(); chk(req, rd_data, exp);
  endtask
  task automatic fill(logic [15:0] p, logic [15:0] d);
    ctl(4'b0001); ex(p, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) model[i] = 16'h0;
    @(negedge clk); tick(); tick(); rst = 0;
    chk("reset busy R7", busy, 0);
    chk("reset err R5", err, 0);
    chk("reset req R3", {ereq, wreq, pload}, 0);

    // R2 and R12: fill, then same-cycle read/fill
    fill(mk_ptr(2'b11, 7'd5, 6'd9, 1'b0), 16'hA5A5); model[9] = 16'hA5A5;
    chk("fill closes window R1", busy, 0);
    rd(6'd9, "fill R2", 16'hA5A5);
    ctl(4'b0001);
    rd_idx = 6'd9; ex(mk_ptr(0, 0, 6'd9, 0), 16'h1234);
    chk("read-first old R12", rd_data, 16'hA5A5);
    tick(); chk("read-first new R12", rd_data, 16'h1234); model[9] = 16'h1234;

    // R5: byte bit set on fill
    fill(mk_ptr(0, 0, 6'd9, 1'b1), 16'hFFFF);
    chk("odd fill err R5", err, 1);
    rd(6'd9, "odd fill no store R5", 16'h1234);

    // R3 erase, R7 busy, R10 buffer kept
    ctl(4'b0011); chk("armed busy R7", busy, 1);
    ex(mk_ptr(2'b10, 7'd77, 0, 0), 16'hDEAD);
    chk("erase req R3", {ereq, wreq}, 2'b10);
    chk("erase page R3", page, 7'd77);
    chk("erase clears err R5", err, 0);
    tick(); chk("erase pulse R3", ereq, 0);
    chk("erase busy R7", busy, 1);
    // R8: control write while busy ignored
    ctl(4'b0011); ex(mk_ptr(0, 7'd3, 0, 0), 0);
    chk("busy ignores cmd R8", {ereq, wreq}, 0);
    finish_op(); chk("erase done busy R7", busy, 0);
    chk("erase no ptr load R6", pload, 0);
    rd(6'd9, "erase keeps buffer R10", 16'h1234);

    // R1 window timing with random delays
    for (int t = 0; t < 10; t++) begin
      automatic int d = (t < 2) ? 4 + t : 1 + ($urandom % 7);
      automatic logic [6:0] pg = 7'($urandom);
      ctl(4'b0011);
      repeat (d - 1) tick();
      ex(mk_ptr(0, pg, 0, 0), 0);
      chk($sformatf("window d=%0d R1", d), ereq, (d <= 4) ? 1 : 0);
      if (d <= 4) begin
        chk("window page R3", page, pg);
        tick(); finish_op();
      end
      chk("window closed R7", busy, 0);
    end

    // R9: unknown code with enable, and enable clear
    ctl(4'b1001); chk("noop armed R9", busy, 1);
    ex(mk_ptr(0, 7'd4, 0, 0), 0);
    chk("noop no req R9", {ereq, wreq}, 0);
    chk("noop closes R9", busy, 0);
    ctl(4'b0011); ctl(4'b0010);
    chk("disable closes R9", busy, 0);
    ex(mk_ptr(0, 7'd4, 0, 0), 0);
    chk("disable no req R9", ereq, 0);

    // R2 random fills against model
    for (int k = 0; k < 40; k++) begin
      automatic logic [5:0] w = 6'($urandom);
      automatic logic [15:0] d = 16'($urandom);
      fill(mk_ptr(2'($urandom), 7'($urandom), w, 1'b0), d);
      model[w] = d;
    end
    for (int i = 0; i < 64; i++) rd(6'(i), "random fill R2", model[i]);

    // R5: misaligned write rejected
    ctl(4'b0101); ex(mk_ptr(0, 7'd20, 6'd4, 0), 0);
    chk("misaligned write err R5", err, 1);
    chk("misaligned write no req R5", wreq, 0);

    // R4, R6, R10: page write at top page (wraps)
    ctl(4'b0101); ex(mk_ptr(2'b11, 7'd127, 0, 0), 16'hBEEF);
    chk("write req R4", {ereq, wreq}, 2'b01);
    chk("write page R4", page, 7'd127);
    chk("write clears err R5", err, 0);
    tick(); rd(6'd9, "buffer before done R10", model[9]);
    finish_op();
    chk("ptr load R6", pload, 1);
    chk("next ptr R6", ptr_o, next_ptr(7'd127));
    tick(); chk("ptr load pulse R6", pload, 0);
    for (int i = 0; i < 64; i += 7) rd(6'(i), "buffer cleared R10", 16'h0);

    // R11: control write and strobe together
    ctl(4'b0011);
    ctl_we = 1; wdata = 4'b0101; ex(mk_ptr(0, 7'd40, 0, 0), 0); ctl_we = 0;
    chk("same-cycle old code R11", {ereq, wreq}, 2'b10);
    chk("same-cycle page R11", page, 7'd40);
    finish_op();
    ex(mk_ptr(0, 7'd41, 0, 0), 0);
    chk("re-armed window R11", {ereq, wreq}, 2'b01);
    chk("re-armed page R4", page, 7'd41);
    tick(); finish_op();
    chk("ptr after write R6", ptr_o, next_ptr(7'd41));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule